// File: doc/BRIEF.md
# UART Hardware Handshake Flow Controller

This block is the handshake unit of one UART channel. It watches the incoming clear-to-send style line and tells the transmitter whether it may start another character. It also drives the outgoing request-to-send style line from the receive FIFO fill level, using a high mark and a low mark with hysteresis between them. One select input picks which modem line pair the unit works on, the RTS/CTS pair or the DTR/DSR pair. That choice covers both directions and the interrupt sources.

The transmitter reports each character start and the moment the stop bit has left the shifter. A stop request from the far end therefore takes effect on the transmitter at a character boundary and never in the middle of a frame. Two sticky status flags report a de-assertion of the watched input and a de-assertion of the driven output. Each flag needs a common master enable and its own enable, and a status read clears both.

Top module: `uart_hwfc`

## Requirements
- R1: With input-side auto control on, a 0-to-1 change of the watched active-low input passes through a two-stage synchronizer, and `tx_ok` goes to 0 on the third rising clock edge after the change. `tx_ok` returns to 1 on the third edge after the input goes back to 0.
- R2: With input-side auto control off, `tx_ok` stays 1 and `tx_paused` stays 0 whatever the watched input does.
- R3: `tx_paused` rises only at a character boundary. If a character is in flight (a `tx_start` has been seen and no `tx_stop_done` since), it stays 0 until the edge that samples `tx_stop_done`. If the transmitter is idle, it rises on the same edge on which `tx_ok` falls. It clears when the input returns to 0.
- R4: `pair_sel` = 0 watches `cts_n`, and `pair_sel` = 1 watches `dsr_n`. The other input has no effect on `tx_ok`.
- R5: A driven line is asserted (pin 0) only while its software request bit is 1 (`sw_rts` for `rts_n`, `sw_dtr` for `dtr_n`). With the request bit at 0 the pin reads 1. With auto control off, the pin follows the request bit one edge later.
- R6: With output-side auto control on, a `rx_level` at or above `rx_hi_mark` de-asserts the selected pin on the next edge. A level at or below `rx_lo_mark` re-asserts it. A level strictly between the marks leaves it unchanged. With auto control off, the level has no effect.
- R7: Output-side auto control acts only on the pin chosen by `pair_sel`. The other pin follows its request bit.
- R8: `irq_in_drop` sets on the edge on which `tx_ok` falls for a new synchronized 0-to-1 input change, but only when both `irq_master_en` and `ien_in_drop` are 1.
- R9: `irq_out_drop` sets on the same edge on which the selected output pin goes from 0 to 1, when both `irq_master_en` and `ien_out_drop` are 1.
- R10: A one-cycle `stat_rd` clears both flags on the next edge. A flag whose set event falls on that same edge stays 1.
- R11: After reset: `rts_n` = 1, `dtr_n` = 1, `tx_ok` = 1, `tx_paused` = 0, and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| auto_out_en | input | 1 | Enable automatic control of the driven line |
| auto_in_en | input | 1 | Enable automatic transmit gating by the watched line |
| irq_master_en | input | 1 | Master enable for both flow-control flags |
| pair_sel | input | 1 | 0: RTS/CTS pair, 1: DTR/DSR pair |
| sw_rts | input | 1 | Software request to assert rts_n |
| sw_dtr | input | 1 | Software request to assert dtr_n |
| ien_in_drop | input | 1 | Enable for the input de-assertion flag |
| ien_out_drop | input | 1 | Enable for the output de-assertion flag |
| cts_n | input | 1 | Clear-to-send, active low, asynchronous |
| dsr_n | input | 1 | Data-set-ready, active low, asynchronous |
| rts_n | output | 1 | Request-to-send, active low |
| dtr_n | output | 1 | Data-terminal-ready, active low |
| tx_start | input | 1 | Transmitter starts a character this cycle |
| tx_stop_done | input | 1 | Stop bit of the current character has been shifted out |
| tx_ok | output | 1 | Transmitter may start a new character |
| tx_paused | output | 1 | Pause in effect at a character boundary |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rx_hi_mark | input | LVL_W | Level at or above which the driven line is de-asserted |
| rx_lo_mark | input | LVL_W | Level at or below which the driven line is re-asserted |
| stat_rd | input | 1 | Status read strobe, clears the flags |
| irq_in_drop | output | 1 | Sticky flag: watched input was de-asserted |
| irq_out_drop | output | 1 | Sticky flag: driven output was de-asserted |

## Verification
A status read and a new set event can land on the same edge. The bench clears the input flag, arms it again, lowers the watched line, then raises it once more. It drives `stat_rd` in the cycle just before the third edge, so the read and the fresh synchronized rise land together, and it expects the flag to stay 1. A later read with no event must then clear the flag. The other collision is a stop request arriving while a character is in flight. The bench expects `tx_ok` to fall on time while `tx_paused` waits for the edge that samples `tx_stop_done`.

// File: rtl/uart_hwfc_pkg.sv
package uart_hwfc_pkg;

    typedef enum logic {
        PAIR_RTS_CTS = 1'b0,
        PAIR_DTR_DSR = 1'b1
    } hwfc_pair_e;

    typedef struct packed {
        logic ok;
        logic paused;
        logic inflight;
    } txg_state_t;

    typedef struct packed {
        logic in_flag;
        logic out_flag;
    } irq_state_t;

    typedef struct packed {
        logic hold;
        logic rts_n;
        logic dtr_n;
    } thr_state_t;

endpackage

// File: rtl/hwfc_sync.sv
module hwfc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out,
    output logic rise
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain_d, chain_q;
    logic              prev_d, prev_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_in};
        prev_d  = chain_q[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= chain_d;
            prev_q  <= prev_d;
        end
    end

    assign sync_out = chain_q[LAST];
    assign rise     = chain_q[LAST] & ~prev_q;

endmodule

// File: rtl/hwfc_tx_gate.sv
module hwfc_tx_gate
    import uart_hwfc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic auto_in_en,
    input  logic line_high,
    input  logic tx_start,
    input  logic tx_stop_done,
    output logic tx_ok,
    output logic tx_paused
);
    txg_state_t st_d, st_q;
    logic       req;

    always_comb begin
        st_d = st_q;
        req  = auto_in_en & line_high;
        st_d.ok = ~req;
        if (tx_start)
            st_d.inflight = 1'b1;
        else if (tx_stop_done)
            st_d.inflight = 1'b0;
        if (!req)
            st_d.paused = 1'b0;
        else if (!st_q.inflight || tx_stop_done)
            st_d.paused = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ok       <= 1'b1;
            st_q.paused   <= 1'b0;
            st_q.inflight <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_ok     = st_q.ok;
    assign tx_paused = st_q.paused;

    p_pause_boundary_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.paused) |-> $past(!st_q.inflight || tx_stop_done))
        else $error("R3 pause began inside a character");

    p_gate_on_request_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_in_en && line_high) |=> !tx_ok)
        else $error("R1 tx_ok not dropped on request");

    p_no_gate_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_in_en |=> (tx_ok && !tx_paused))
        else $error("R2 gating while auto input control off");

endmodule

// File: rtl/hwfc_rx_throttle.sv
module hwfc_rx_throttle
    import uart_hwfc_pkg::*;
#(
    parameter int LVL_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             auto_out_en,
    input  hwfc_pair_e       pair,
    input  logic             sw_rts,
    input  logic             sw_dtr,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] rx_hi_mark,
    input  logic [LVL_W-1:0] rx_lo_mark,
    output logic             rts_n,
    output logic             dtr_n,
    output logic             drop_evt
);
    thr_state_t st_d, st_q;
    logic       sel_n_d, sel_n_q;

    always_comb begin
        st_d = st_q;
        if (!auto_out_en)
            st_d.hold = 1'b0;
        else if (rx_level >= rx_hi_mark)
            st_d.hold = 1'b1;
        else if (rx_level <= rx_lo_mark)
            st_d.hold = 1'b0;
        st_d.rts_n = ~(sw_rts & ~(auto_out_en & (pair == PAIR_RTS_CTS) & st_d.hold));
        st_d.dtr_n = ~(sw_dtr & ~(auto_out_en & (pair == PAIR_DTR_DSR) & st_d.hold));
        sel_n_d  = (pair == PAIR_DTR_DSR) ? st_d.dtr_n : st_d.rts_n;
        sel_n_q  = (pair == PAIR_DTR_DSR) ? st_q.dtr_n : st_q.rts_n;
        drop_evt = sel_n_d & ~sel_n_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.hold  <= 1'b0;
            st_q.rts_n <= 1'b1;
            st_q.dtr_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rts_n = st_q.rts_n;
    assign dtr_n = st_q.dtr_n;

    p_manual_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_rts |=> rts_n)
        else $error("R5 rts_n asserted without request");

    p_high_mark_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_out_en && pair == PAIR_RTS_CTS && rx_level >= rx_hi_mark) |=> rts_n)
        else $error("R6 rts_n kept asserted at high mark");

    p_other_pin_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pair == PAIR_RTS_CTS && sw_dtr) |=> !dtr_n)
        else $error("R7 unselected dtr_n disturbed");

endmodule

// File: rtl/hwfc_irq.sv
module hwfc_irq
    import uart_hwfc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic master_en,
    input  logic ien_in,
    input  logic ien_out,
    input  logic in_evt,
    input  logic out_evt,
    input  logic stat_rd,
    output logic in_flag,
    output logic out_flag
);
    irq_state_t st_d, st_q;
    logic       set_in, set_out;

    always_comb begin
        st_d    = st_q;
        set_in  = in_evt & master_en & ien_in;
        set_out = out_evt & master_en & ien_out;
        if (set_in)
            st_d.in_flag = 1'b1;
        else if (stat_rd)
            st_d.in_flag = 1'b0;
        if (set_out)
            st_d.out_flag = 1'b1;
        else if (stat_rd)
            st_d.out_flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_flag  = st_q.in_flag;
    assign out_flag = st_q.out_flag;

    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_evt && master_en && ien_in && stat_rd) |=> in_flag)
        else $error("R10 read dropped a coinciding event");

    p_read_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !in_evt && !out_evt) |=> (!in_flag && !out_flag))
        else $error("R10 read did not clear");

    p_master_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_en && !in_flag) |=> !in_flag)
        else $error("R8 flag set without master enable");

    p_out_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_evt && master_en && ien_out) |=> out_flag)
        else $error("R9 output drop not flagged");

endmodule

// File: rtl/uart_hwfc.sv
module uart_hwfc
    import uart_hwfc_pkg::*;
#(
    parameter int LVL_W       = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             auto_out_en,
    input  logic             auto_in_en,
    input  logic             irq_master_en,
    input  logic             pair_sel,
    input  logic             sw_rts,
    input  logic             sw_dtr,
    input  logic             ien_in_drop,
    input  logic             ien_out_drop,
    input  logic             cts_n,
    input  logic             dsr_n,
    output logic             rts_n,
    output logic             dtr_n,
    input  logic             tx_start,
    input  logic             tx_stop_done,
    output logic             tx_ok,
    output logic             tx_paused,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] rx_hi_mark,
    input  logic [LVL_W-1:0] rx_lo_mark,
    input  logic             stat_rd,
    output logic             irq_in_drop,
    output logic             irq_out_drop
);
    hwfc_pair_e pair;
    logic       watched_raw;
    logic       watched_sync;
    logic       watched_rise;
    logic       out_drop;

    assign pair        = hwfc_pair_e'(pair_sel);
    assign watched_raw = (pair == PAIR_DTR_DSR) ? dsr_n : cts_n;

    hwfc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (watched_raw),
        .sync_out (watched_sync),
        .rise     (watched_rise)
    );

    hwfc_tx_gate u_gate (
        .clk          (clk),
        .rst_n        (rst_n),
        .auto_in_en   (auto_in_en),
        .line_high    (watched_sync),
        .tx_start     (tx_start),
        .tx_stop_done (tx_stop_done),
        .tx_ok        (tx_ok),
        .tx_paused    (tx_paused)
    );

    hwfc_rx_throttle #(.LVL_W(LVL_W)) u_thr (
        .clk         (clk),
        .rst_n       (rst_n),
        .auto_out_en (auto_out_en),
        .pair        (pair),
        .sw_rts      (sw_rts),
        .sw_dtr      (sw_dtr),
        .rx_level    (rx_level),
        .rx_hi_mark  (rx_hi_mark),
        .rx_lo_mark  (rx_lo_mark),
        .rts_n       (rts_n),
        .dtr_n       (dtr_n),
        .drop_evt    (out_drop)
    );

    hwfc_irq u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .master_en (irq_master_en),
        .ien_in    (ien_in_drop),
        .ien_out   (ien_out_drop),
        .in_evt    (watched_rise),
        .out_evt   (out_drop),
        .stat_rd   (stat_rd),
        .in_flag   (irq_in_drop),
        .out_flag  (irq_out_drop)
    );

endmodule

// File: tb/uart_hwfc_test.sv
module uart_hwfc_test;
    localparam int LVL_W = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic auto_out_en = 0, auto_in_en = 0, irq_master_en = 0, pair_sel = 0;
    logic sw_rts = 0, sw_dtr = 0, ien_in_drop = 0, ien_out_drop = 0;
    logic cts_n = 0, dsr_n = 0, tx_start = 0, tx_stop_done = 0, stat_rd = 0;
    logic [LVL_W-1:0] rx_level = '0, rx_hi_mark = 7'd48, rx_lo_mark = 7'd16;
    logic rts_n, dtr_n, tx_ok, tx_paused, irq_in_drop, irq_out_drop;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    uart_hwfc #(.LVL_W(LVL_W)) uut (
        .clk(clk), .rst_n(rst_n), .auto_out_en(auto_out_en), .auto_in_en(auto_in_en),
        .irq_master_en(irq_master_en), .pair_sel(pair_sel), .sw_rts(sw_rts), .sw_dtr(sw_dtr),
        .ien_in_drop(ien_in_drop), .ien_out_drop(ien_out_drop), .cts_n(cts_n), .dsr_n(dsr_n),
        .rts_n(rts_n), .dtr_n(dtr_n), .tx_start(tx_start), .tx_stop_done(tx_stop_done),
        .tx_ok(tx_ok), .tx_paused(tx_paused), .rx_level(rx_level), .rx_hi_mark(rx_hi_mark),
        .rx_lo_mark(rx_lo_mark), .stat_rd(stat_rd), .irq_in_drop(irq_in_drop),
        .irq_out_drop(irq_out_drop)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic read_status();
        stat_rd = 1'b1;
        tick(1);
        stat_rd = 1'b0;
    endtask

    task automatic t_reset();
        tick(1);
        chk("R11", "rts_n", rts_n, 1'b1);
        chk("R11", "dtr_n", dtr_n, 1'b1);
        chk("R11", "tx_ok", tx_ok, 1'b1);
        chk("R11", "tx_paused", tx_paused, 1'b0);
        chk("R11", "irq_in_drop", irq_in_drop, 1'b0);
        chk("R11", "irq_out_drop", irq_out_drop, 1'b0);
        rst_n = 1'b1;
        tick(2);
    endtask

    task automatic t_input_gate();
        auto_in_en = 1; pair_sel = 0; cts_n = 0;
        tick(4);
        cts_n = 1;
        tick(2);
        chk("R1", "tx_ok before third edge", tx_ok, 1'b1);
        tick(1);
        chk("R1", "tx_ok on third edge", tx_ok, 1'b0);
        chk("R3", "idle pause on third edge", tx_paused, 1'b1);
        cts_n = 0;
        tick(2);
        chk("R1", "tx_ok still low", tx_ok, 1'b0);
        tick(1);
        chk("R1", "tx_ok resumed", tx_ok, 1'b1);
        chk("R3", "pause cleared", tx_paused, 1'b0);
        auto_in_en = 0; cts_n = 1;
        tick(5);
        chk("R2", "tx_ok with auto off", tx_ok, 1'b1);
        chk("R2", "tx_paused with auto off", tx_paused, 1'b0);
        cts_n = 0;
        tick(4);
    endtask

    task automatic t_pair_input();
        auto_in_en = 1; pair_sel = 1; cts_n = 1; dsr_n = 0;
        tick(5);
        chk("R4", "cts_n ignored in DTR/DSR mode", tx_ok, 1'b1);
        dsr_n = 1;
        tick(3);
        chk("R4", "dsr_n watched in DTR/DSR mode", tx_ok, 1'b0);
        dsr_n = 0; cts_n = 0;
        tick(3);
        chk("R4", "dsr_n release", tx_ok, 1'b1);
        pair_sel = 0; dsr_n = 1;
        tick(5);
        chk("R4", "dsr_n ignored in RTS/CTS mode", tx_ok, 1'b1);
        dsr_n = 0;
        tick(2);
    endtask

    task automatic t_boundary();
        auto_in_en = 1; pair_sel = 0; cts_n = 0;
        tx_start = 1;
        tick(1);
        tx_start = 0;
        cts_n = 1;
        tick(3);
        chk("R1", "tx_ok drops mid character", tx_ok, 1'b0);
        chk("R3", "no pause mid character", tx_paused, 1'b0);
        tick(4);
        chk("R3", "still no pause mid character", tx_paused, 1'b0);
        tx_stop_done = 1;
        tick(1);
        tx_stop_done = 0;
        chk("R3", "pause after stop bit", tx_paused, 1'b1);
        cts_n = 0;
        tick(3);
        chk("R3", "pause released", tx_paused, 1'b0);
        tick(2);
    endtask

    task automatic t_out_manual();
        auto_out_en = 0; sw_rts = 0; sw_dtr = 0; rx_level = 7'd60;
        tick(1);
        chk("R5", "rts_n without request", rts_n, 1'b1);
        sw_rts = 1;
        tick(1);
        chk("R5", "rts_n follows request", rts_n, 1'b0);
        sw_dtr = 1;
        tick(1);
        chk("R5", "dtr_n follows request", dtr_n, 1'b0);
        chk("R6", "level ignored with auto off", rts_n, 1'b0);
        auto_out_en = 1; sw_rts = 0; rx_level = 7'd0;
        tick(1);
        chk("R5", "auto needs request", rts_n, 1'b1);
        sw_rts = 1;
        tick(1);
    endtask

    task automatic t_out_auto();
        auto_out_en = 1; pair_sel = 0; sw_rts = 1; sw_dtr = 1;
        rx_hi_mark = 7'd48; rx_lo_mark = 7'd16; rx_level = 7'd20;
        tick(1);
        chk("R6", "below high mark", rts_n, 1'b0);
        rx_level = 7'd48;
        tick(1);
        chk("R6", "at high mark", rts_n, 1'b1);
        chk("R7", "dtr_n untouched", dtr_n, 1'b0);
        rx_level = 7'd30;
        tick(1);
        chk("R6", "hysteresis hold", rts_n, 1'b1);
        rx_level = 7'd17;
        tick(1);
        chk("R6", "just above low mark", rts_n, 1'b1);
        rx_level = 7'd16;
        tick(1);
        chk("R6", "at low mark", rts_n, 0);
        pair_sel = 1; rx_level = 7'd50;
        tick(1);
        chk("R7", "dtr_n throttled", dtr_n, 1'b1);
        chk("R7", "rts_n untouched", rts_n, 1'b0);
        rx_level = 7'd0;
        tick(1);
        chk("R7", "dtr_n restored", dtr_n, 1'b0);
        pair_sel = 0;
        tick(1);
    endtask

    task automatic t_irq();
        auto_in_en = 1; pair_sel = 0; cts_n = 0;
        irq_master_en = 1; ien_in_drop = 1; ien_out_drop = 1;
        tick(4);
        read_status();
        cts_n = 1;
        tick(3);
        chk("R8", "input drop flagged", irq_in_drop, 1'b1);
        read_status();
        chk("R10", "read clears input flag", irq_in_drop, 1'b0);
        cts_n = 0;
        tick(4);
        irq_master_en = 0;
        cts_n = 1;
        tick(4);
        chk("R8", "no flag without master", irq_in_drop, 1'b0);
        cts_n = 0;
        tick(4);
        irq_master_en = 1; ien_in_drop = 0;
        cts_n = 1;
        tick(4);
        chk("R8", "no flag without own enable", irq_in_drop, 1'b0);
        cts_n = 0;
        tick(4);
        ien_in_drop = 1;
        cts_n = 1;
        tick(3);
        cts_n = 0;
        tick(4);
        cts_n = 1;
        tick(2);
        stat_rd = 1;
        tick(1);
        stat_rd = 0;
        chk("R10", "event beats coinciding read", irq_in_drop, 1'b1);
        read_status();
        chk("R10", "later read clears", irq_in_drop, 1'b0);
        cts_n = 0;
        tick(4);
        auto_out_en = 1; sw_rts = 1; rx_level = 7'd0;
        tick(1);
        read_status();
        rx_level = 7'd50;
        tick(1);
        chk("R9", "rts_n dropped", rts_n, 1'b1);
        chk("R9", "output drop flagged", irq_out_drop, 1'b1);
        rx_level = 7'd0;
        tick(1);
        read_status();
        chk("R10", "read clears output flag", irq_out_drop, 1'b0);
    endtask

    initial begin
        #(200000 * 10);
        bad++;
        total++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_input_gate();
        t_pair_input();
        t_boundary();
        t_out_manual();
        t_out_auto();
        t_irq();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule